// File: doc/BRIEF.md
# Hash Engine Memory Access Sequencer

This block drives all memory traffic for one compression call of a 256-bit hash. A one-cycle start strobe brings a space identifier, an execution stamp and three base addresses: one for the chaining state, one for the message block and one for the result. The block reads the eight state words in a single parallel burst. It then loads the sixteen message words one per round, and finally writes eight result words in a single parallel burst. The state burst and the result burst share one eight-lane address/data/tag path, and the phase sets its direction.

Every word read carries a type tag, and each one must carry the unsigned 32-bit code. The block checks before any access that all three address windows fit in the address space. A range fault skips every access. A bad tag in the state burst stops the operation before any message load. A bad tag on a message load stops it before the next load and before the write. The round arithmetic is outside this block. A placeholder produces result word i as state word i plus the 32-bit sum of the sixteen message words.

Top module: `hash_mem_seq`

## Requirements
- R1: After reset, laneValid, inValid and doneValid are all 0 until a start is accepted.
- R2: In the cycle after an accepted start, the block issues one read burst: laneValid=1, laneWrite=0, lane i address = state base + i, with reqSpace and reqStamp equal to the values given with the start.
- R3: The next sixteen cycles each carry one message load: inValid=1, and load k (k = 0..15) uses address input base + k.
- R4: The cycle after the last load is one write burst: laneValid=1, laneWrite=1, lane i address = output base + i, laneWrTag = 4 (the unsigned 32-bit code), and data = state word i + sum of the sixteen loaded words (mod 2^32).
- R5: doneValid is high for exactly one cycle, 19 cycles after the start is accepted on a clean run, with doneErr = 0.
- R6: If base + burst length - 1 exceeds 2^ADDR_W - 1 for any window (lengths 8, 16, 8), no access is issued. doneValid rises in the cycle after the start with doneErr = 1. A window ending exactly at the top address is legal.
- R7: If any state-burst tag differs from 4, no message load and no write follow. doneValid comes 2 cycles after the start with doneErr = 2.
- R8: If message load k returns a tag other than 4, no further loads and no write follow. doneValid comes k+3 cycles after the start with doneErr = 3.
- R9: A start strobe while an operation is in progress is ignored and does not change that operation's addresses, results or done count.
- R10: laneWrite is high only together with laneValid, and laneValid and inValid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe, taken only when idle |
| startSpace | input | SPACE_W | Space identifier for the operation |
| startStamp | input | STAMP_W | Execution stamp for the operation |
| startStateAddr | input | ADDR_W | Base address of the state window |
| startInAddr | input | ADDR_W | Base address of the message window |
| startOutAddr | input | ADDR_W | Base address of the result window |
| reqSpace | output | SPACE_W | Space identifier on every request |
| reqStamp | output | STAMP_W | Execution stamp on every request |
| laneValid | output | 1 | Eight-lane burst request |
| laneWrite | output | 1 | Burst direction: 1 write, 0 read |
| laneAddr | output | LANES*ADDR_W | Lane addresses, lane 0 in the low bits |
| laneWrData | output | LANES*WORD_W | Result words for the write burst |
| laneWrTag | output | TAG_W | Tag written with every result word |
| laneRdData | input | LANES*WORD_W | Lane read data |
| laneRdTag | input | LANES*TAG_W | Lane read tags |
| inValid | output | 1 | Single message load request |
| inAddr | output | ADDR_W | Message load address |
| inRdData | input | WORD_W | Message load data |
| inRdTag | input | TAG_W | Message load tag |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 2 | 0 ok, 1 range, 2 state tag, 3 message tag |

## Verification
The bench builds the block with ADDR_W = 8, which shrinks the address space to 256 words. That makes the top-of-space boundary directly reachable: a state window based at 248 and a message window based at 240 fit exactly, while bases of 249 or 241 overflow. The other parameters keep their defaults: eight lanes, sixteen rounds and a 3-bit tag with code 4. The run length is therefore 19 cycles, and tag faults can be placed on a chosen lane or on a chosen message round.

// File: rtl/hms_pkg.sv
package hms_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_STATE,
    PH_INPUT,
    PH_WRITE,
    PH_DONE
  } phase_t;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_RANGE     = 2'd1,
    ERR_STATE_TAG = 2'd2,
    ERR_INPUT_TAG = 2'd3
  } err_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic loadState;
    logic loadInput;
  } strobe_t;

endpackage

// File: rtl/hms_ctrl.sv
module hms_ctrl
  import hms_pkg::*;
#(
  parameter int ROUNDS = 16,
  localparam int RIDX_W = $clog2(ROUNDS),
  localparam int CNT_W  = RIDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              rangeErr,
  input  logic              stateTagErr,
  input  logic              inTagErr,
  output strobe_t           strobe,
  output logic              laneValid,
  output logic              laneWrite,
  output logic              inValid,
  output logic [RIDX_W-1:0] roundIdx,
  output logic              doneValid,
  output logic [1:0]        doneErr
);

  phase_t           phase, phaseNxt;
  err_t             errQ, errNxt;
  logic [CNT_W-1:0] roundsLeft, leftNxt;

  always_comb begin
    phaseNxt  = phase;
    errNxt    = errQ;
    leftNxt   = roundsLeft;
    strobe    = '0;
    laneValid = 1'b0;
    laneWrite = 1'b0;
    inValid   = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (startValid) begin
          strobe.loadStart = 1'b1;
          if (rangeErr) begin
            errNxt   = ERR_RANGE;
            phaseNxt = PH_DONE;
          end else begin
            errNxt   = ERR_NONE;
            phaseNxt = PH_STATE;
          end
        end
      end
      PH_STATE: begin
        laneValid = 1'b1;
        if (stateTagErr) begin
          errNxt   = ERR_STATE_TAG;
          phaseNxt = PH_DONE;
        end else begin
          strobe.loadState = 1'b1;
          leftNxt  = CNT_W'(ROUNDS);
          phaseNxt = PH_INPUT;
        end
      end
      PH_INPUT: begin
        inValid = 1'b1;
        if (inTagErr) begin
          errNxt   = ERR_INPUT_TAG;
          phaseNxt = PH_DONE;
        end else begin
          strobe.loadInput = 1'b1;
          leftNxt = roundsLeft - CNT_W'(1);
          if (roundsLeft == CNT_W'(1)) phaseNxt = PH_WRITE;
        end
      end
      PH_WRITE: begin
        laneValid = 1'b1;
        laneWrite = 1'b1;
        phaseNxt  = PH_DONE;
      end
      PH_DONE:  phaseNxt = PH_IDLE;
      default:  phaseNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      errQ       <= ERR_NONE;
      roundsLeft <= '0;
    end else begin
      phase      <= phaseNxt;
      errQ       <= errNxt;
      roundsLeft <= leftNxt;
    end
  end

  assign roundIdx  = RIDX_W'(CNT_W'(ROUNDS) - roundsLeft);
  assign doneValid = (phase == PH_DONE);
  assign doneErr   = doneValid ? errQ : ERR_NONE;

endmodule

// File: rtl/hms_dp.sv
module hms_dp
  import hms_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int ROUNDS  = 16,
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 32,
  parameter int TAG_W   = 3,
  parameter int TAG_U32 = 4,
  parameter int SPACE_W = 16,
  parameter int STAMP_W = 32,
  localparam int RIDX_W = $clog2(ROUNDS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobe,
  input  logic                      laneWrite,
  input  logic [RIDX_W-1:0]         roundIdx,
  input  logic [SPACE_W-1:0]        startSpace,
  input  logic [STAMP_W-1:0]        startStamp,
  input  logic [ADDR_W-1:0]         startStateAddr,
  input  logic [ADDR_W-1:0]         startInAddr,
  input  logic [ADDR_W-1:0]         startOutAddr,
  input  logic [LANES*WORD_W-1:0]   laneRdData,
  input  logic [LANES*TAG_W-1:0]    laneRdTag,
  input  logic [WORD_W-1:0]         inRdData,
  input  logic [TAG_W-1:0]          inRdTag,
  output logic                      rangeErr,
  output logic                      stateTagErr,
  output logic                      inTagErr,
  output logic [SPACE_W-1:0]        reqSpace,
  output logic [STAMP_W-1:0]        reqStamp,
  output logic [LANES*ADDR_W-1:0]   laneAddr,
  output logic [LANES*WORD_W-1:0]   laneWrData,
  output logic [ADDR_W-1:0]         inAddr
);

  logic [ADDR_W-1:0] stateBase, inBase, outBase;
  logic [WORD_W-1:0] msgSum;
  logic [WORD_W-1:0] stateWord [LANES];
  logic [LANES*TAG_W-1:0] tagBatch;

  function automatic logic overTop(input logic [ADDR_W-1:0] base, input int len);
    logic [ADDR_W:0] last;
    last = {1'b0, base} + (ADDR_W+1)'(len - 1);
    return last[ADDR_W];
  endfunction

  assign rangeErr = overTop(startStateAddr, LANES) |
                    overTop(startInAddr, ROUNDS)   |
                    overTop(startOutAddr, LANES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateBase <= '0;
      inBase    <= '0;
      outBase   <= '0;
      reqSpace  <= '0;
      reqStamp  <= '0;
      msgSum    <= '0;
    end else begin
      if (strobe.loadStart) begin
        stateBase <= startStateAddr;
        inBase    <= startInAddr;
        outBase   <= startOutAddr;
        reqSpace  <= startSpace;
        reqStamp  <= startStamp;
        msgSum    <= '0;
      end
      if (strobe.loadInput) msgSum <= msgSum + inRdData;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      // per-lane tag difference packed into its own field of the batch word
      assign tagBatch[g*TAG_W +: TAG_W] = laneRdTag[g*TAG_W +: TAG_W] - TAG_W'(TAG_U32);

      always_ff @(posedge clk) begin
        if (!rstN) stateWord[g] <= '0;
        else if (strobe.loadState) stateWord[g] <= laneRdData[g*WORD_W +: WORD_W];
      end

      assign laneAddr[g*ADDR_W +: ADDR_W] =
        (laneWrite ? outBase : stateBase) + ADDR_W'(g);
      // placeholder for the round function
      assign laneWrData[g*WORD_W +: WORD_W] = stateWord[g] + msgSum;
    end
  endgenerate

  assign stateTagErr = |tagBatch;
  assign inTagErr    = (inRdTag != TAG_W'(TAG_U32));
  assign inAddr      = inBase + ADDR_W'(roundIdx);

endmodule

// File: rtl/hash_mem_seq.sv
module hash_mem_seq
  import hms_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int ROUNDS  = 16,
  parameter int ADDR_W  = 16,
  parameter int WORD_W  = 32,
  parameter int TAG_W   = 3,
  parameter int TAG_U32 = 4,
  parameter int SPACE_W = 16,
  parameter int STAMP_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startValid,
  input  logic [SPACE_W-1:0]      startSpace,
  input  logic [STAMP_W-1:0]      startStamp,
  input  logic [ADDR_W-1:0]       startStateAddr,
  input  logic [ADDR_W-1:0]       startInAddr,
  input  logic [ADDR_W-1:0]       startOutAddr,
  output logic [SPACE_W-1:0]      reqSpace,
  output logic [STAMP_W-1:0]      reqStamp,
  output logic                    laneValid,
  output logic                    laneWrite,
  output logic [LANES*ADDR_W-1:0] laneAddr,
  output logic [LANES*WORD_W-1:0] laneWrData,
  output logic [TAG_W-1:0]        laneWrTag,
  input  logic [LANES*WORD_W-1:0] laneRdData,
  input  logic [LANES*TAG_W-1:0]  laneRdTag,
  output logic                    inValid,
  output logic [ADDR_W-1:0]       inAddr,
  input  logic [WORD_W-1:0]       inRdData,
  input  logic [TAG_W-1:0]        inRdTag,
  output logic                    doneValid,
  output logic [1:0]              doneErr
);

  localparam int RIDX_W = $clog2(ROUNDS);

  strobe_t           strobe;
  logic              rangeErr, stateTagErr, inTagErr;
  logic [RIDX_W-1:0] roundIdx;

  assign laneWrTag = TAG_W'(TAG_U32);

  hms_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .rangeErr(rangeErr), .stateTagErr(stateTagErr), .inTagErr(inTagErr),
    .strobe(strobe), .laneValid(laneValid), .laneWrite(laneWrite),
    .inValid(inValid), .roundIdx(roundIdx),
    .doneValid(doneValid), .doneErr(doneErr)
  );

  hms_dp #(
    .LANES(LANES), .ROUNDS(ROUNDS), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .TAG_W(TAG_W), .TAG_U32(TAG_U32), .SPACE_W(SPACE_W), .STAMP_W(STAMP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .laneWrite(laneWrite),
    .roundIdx(roundIdx), .startSpace(startSpace), .startStamp(startStamp),
    .startStateAddr(startStateAddr), .startInAddr(startInAddr),
    .startOutAddr(startOutAddr), .laneRdData(laneRdData), .laneRdTag(laneRdTag),
    .inRdData(inRdData), .inRdTag(inRdTag), .rangeErr(rangeErr),
    .stateTagErr(stateTagErr), .inTagErr(inTagErr), .reqSpace(reqSpace),
    .reqStamp(reqStamp), .laneAddr(laneAddr), .laneWrData(laneWrData),
    .inAddr(inAddr)
  );

endmodule

// File: rtl/hms_checker.sv
module hms_checker #(
  parameter int LANES   = 8,
  parameter int ADDR_W  = 16,
  parameter int SPACE_W = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    laneValid,
  input logic                    laneWrite,
  input logic [LANES*ADDR_W-1:0] laneAddr,
  input logic                    inValid,
  input logic [ADDR_W-1:0]       inAddr,
  input logic [SPACE_W-1:0]      reqSpace,
  input logic                    doneValid,
  input logic [1:0]              doneErr
);

  logic lanesInOrder;
  always_comb begin
    lanesInOrder = 1'b1;
    for (int i = 1; i < LANES; i++)
      if (laneAddr[i*ADDR_W +: ADDR_W] != laneAddr[0 +: ADDR_W] + ADDR_W'(i))
        lanesInOrder = 1'b0;
  end

  assert_dir_with_burst_R10: assert property (@(posedge clk) disable iff (!rstN)
    laneWrite |-> laneValid);

  assert_paths_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(laneValid && inValid));

  assert_lanes_consecutive_R2: assert property (@(posedge clk) disable iff (!rstN)
    laneValid |-> lanesInOrder);

  assert_input_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && $past(inValid)) |-> (inAddr == $past(inAddr) + ADDR_W'(1)));

  assert_write_follows_input_R4: assert property (@(posedge clk) disable iff (!rstN)
    (laneValid && laneWrite) |-> $past(inValid));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_range_no_access_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneErr == 2'd1) |-> $past(!laneValid && !inValid));

  assert_state_fault_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneErr == 2'd2) |-> $past(laneValid && !laneWrite));

  assert_space_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((laneValid || inValid) && $past(laneValid || inValid)) |-> $stable(reqSpace));

endmodule

bind hash_mem_seq hms_checker #(.LANES(LANES), .ADDR_W(ADDR_W), .SPACE_W(SPACE_W)) u_chk (
  .clk(clk), .rstN(rstN), .laneValid(laneValid), .laneWrite(laneWrite),
  .laneAddr(laneAddr), .inValid(inValid), .inAddr(inAddr), .reqSpace(reqSpace),
  .doneValid(doneValid), .doneErr(doneErr)
);

// File: tb/hash_mem_seq_tb.sv
module hash_mem_seq_tb;
  localparam int LANES = 8, ROUNDS = 16, AW = 8, WW = 32, TW = 3, U32 = 4;
  localparam int SW = 16, CW = 32, DEPTH = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic            startValid = 1'b0;
  logic [SW-1:0]   startSpace = '0;
  logic [CW-1:0]   startStamp = '0;
  logic [AW-1:0]   startStateAddr = '0, startInAddr = '0, startOutAddr = '0;
  logic [SW-1:0]   reqSpace;
  logic [CW-1:0]   reqStamp;
  logic            laneValid, laneWrite, inValid, doneValid;
  logic [LANES*AW-1:0] laneAddr;
  logic [LANES*WW-1:0] laneWrData, laneRdData;
  logic [LANES*TW-1:0] laneRdTag;
  logic [TW-1:0]   laneWrTag, inRdTag;
  logic [AW-1:0]   inAddr;
  logic [WW-1:0]   inRdData;
  logic [1:0]      doneErr;

  hash_mem_seq #(.LANES(LANES), .ROUNDS(ROUNDS), .ADDR_W(AW), .WORD_W(WW),
    .TAG_W(TW), .TAG_U32(U32), .SPACE_W(SW), .STAMP_W(CW)) u_dut (.*);

  // tagged memory model
  logic [WW-1:0] memVal [DEPTH];
  logic [TW-1:0] memTag [DEPTH];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      laneRdData[i*WW +: WW] = memVal[laneAddr[i*AW +: AW]];
      laneRdTag[i*TW +: TW]  = memTag[laneAddr[i*AW +: AW]];
    end
    inRdData = memVal[inAddr];
    inRdTag  = memTag[inAddr];
  end

  int nTests = 0, nFail = 0;
  int cyc, nState, nIn, nWrite, nDone, doneCyc, laneBad, inBad, tagBad, idBad;
  logic [1:0] doneCode;
  logic [AW-1:0] expState, expIn, expOut;
  logic [SW-1:0] expSpace;
  logic [CW-1:0] expStamp;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor samples mid high phase
  always @(posedge clk) begin
    #5;
    cyc++;
    if (laneValid && !laneWrite) begin
      nState++;
      for (int i = 0; i < LANES; i++)
        if (laneAddr[i*AW +: AW] != expState + AW'(i)) laneBad++;
      if (reqSpace != expSpace || reqStamp != expStamp) idBad++;
    end
    if (laneValid && laneWrite) begin
      nWrite++;
      if (laneWrTag != TW'(U32)) tagBad++;
      if (reqSpace != expSpace || reqStamp != expStamp) idBad++;
      for (int i = 0; i < LANES; i++) begin
        if (laneAddr[i*AW +: AW] != expOut + AW'(i)) laneBad++;
        memVal[laneAddr[i*AW +: AW]] = laneWrData[i*WW +: WW];
        memTag[laneAddr[i*AW +: AW]] = laneWrTag;
      end
    end
    if (inValid) begin
      if (inAddr != expIn + AW'(nIn)) inBad++;
      if (reqSpace != expSpace) idBad++;
      nIn++;
    end
    if (doneValid) begin
      nDone++;
      doneCyc  = cyc;
      doneCode = doneErr;
    end
  end

  int tick = 0;
  always @(posedge clk) begin
    tick++;
    if (tick == 50000) begin
      nFail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d", tick, 50000);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic fill_mem();
    for (int a = 0; a < DEPTH; a++) begin
      memVal[a] = 32'h9e3779b9 * (a + 1) ^ 32'h00c0ffee;
      memTag[a] = TW'(U32);
    end
  endtask

  task automatic launch(input logic [SW-1:0] sp, input logic [CW-1:0] st,
                        input logic [AW-1:0] sb, input logic [AW-1:0] ib,
                        input logic [AW-1:0] ob);
    @(negedge clk);
    expState = sb; expIn = ib; expOut = ob; expSpace = sp; expStamp = st;
    nState = 0; nIn = 0; nWrite = 0; nDone = 0; doneCyc = -1;
    laneBad = 0; inBad = 0; tagBad = 0; idBad = 0; doneCode = '0;
    startValid = 1'b1; startSpace = sp; startStamp = st;
    startStateAddr = sb; startInAddr = ib; startOutAddr = ob;
    cyc = 0;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 40 && nDone == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic clean_run(input string tag, input logic [SW-1:0] sp,
                           input logic [CW-1:0] st, input logic [AW-1:0] sb,
                           input logic [AW-1:0] ib, input logic [AW-1:0] ob);
    logic [WW-1:0] sum, expW [LANES];
    int bad;
    sum = '0;
    for (int k = 0; k < ROUNDS; k++) sum += memVal[ib + AW'(k)];
    for (int i = 0; i < LANES; i++) expW[i] = memVal[sb + AW'(i)] + sum;
    launch(sp, st, sb, ib, ob);
    settle();
    chk({"R2 state burst count ", tag}, nState, 1);
    chk({"R2 lane addresses ", tag}, laneBad, 0);
    chk({"R2 space/stamp ", tag}, idBad, 0);
    chk({"R3 load count ", tag}, nIn, ROUNDS);
    chk({"R3 load addresses ", tag}, inBad, 0);
    chk({"R4 write count ", tag}, nWrite, 1);
    chk({"R4 write tag ", tag}, tagBad, 0);
    bad = 0;
    for (int i = 0; i < LANES; i++)
      if (memVal[ob + AW'(i)] !== expW[i] || memTag[ob + AW'(i)] !== TW'(U32)) bad++;
    chk({"R4 result words ", tag}, bad, 0);
    chk({"R5 done count ", tag}, nDone, 1);
    chk({"R5 done cycle ", tag}, doneCyc, 19);
    chk({"R5 done code ", tag}, doneCode, 0);
  endtask

  task automatic t_reset();
    int seen = 0;
    repeat (5) begin
      @(negedge clk);
      if (laneValid || inValid || doneValid) seen++;
    end
    chk("R1 idle after reset", seen, 0);
  endtask

  task automatic t_range(input string tag, input logic [AW-1:0] sb,
                         input logic [AW-1:0] ib, input logic [AW-1:0] ob);
    launch(16'h0bad, 32'h1, sb, ib, ob);
    settle();
    chk({"R6 no burst ", tag}, nState + nWrite, 0);
    chk({"R6 no load ", tag}, nIn, 0);
    chk({"R6 done cycle ", tag}, doneCyc, 1);
    chk({"R6 done code ", tag}, doneCode, 1);
  endtask

  task automatic t_state_tag();
    memTag[8'd53] = 3'd1;
    launch(16'h0042, 32'h77, 8'd48, 8'd100, 8'd200);
    settle();
    chk("R7 one read burst", nState, 1);
    chk("R7 no loads", nIn, 0);
    chk("R7 no write", nWrite, 0);
    chk("R7 done cycle", doneCyc, 2);
    chk("R7 done code", doneCode, 2);
    memTag[8'd53] = TW'(U32);
  endtask

  task automatic t_input_tag();
    memTag[8'd106] = 3'd0;
    launch(16'h0043, 32'h78, 8'd48, 8'd100, 8'd200);
    settle();
    chk("R8 loads before fault", nIn, 7);
    chk("R8 load addresses", inBad, 0);
    chk("R8 no write", nWrite, 0);
    chk("R8 done cycle", doneCyc, 9);
    chk("R8 done code", doneCode, 3);
    memTag[8'd106] = TW'(U32);
  endtask

  task automatic t_busy();
    logic [WW-1:0] sum, expW [LANES];
    int bad;
    sum = '0;
    for (int k = 0; k < ROUNDS; k++) sum += memVal[8'd64 + AW'(k)];
    for (int i = 0; i < LANES; i++) expW[i] = memVal[8'd32 + AW'(i)] + sum;
    launch(16'h0055, 32'h99, 8'd32, 8'd64, 8'd160);
    repeat (3) @(negedge clk);
    startValid = 1'b1; startStateAddr = 8'd0; startInAddr = 8'd0;
    startOutAddr = 8'd0; startSpace = 16'hffff;
    @(negedge clk);
    startValid = 1'b0;
    settle();
    chk("R9 single state burst", nState, 1);
    chk("R9 addresses unchanged", laneBad + inBad + idBad, 0);
    chk("R9 single done", nDone, 1);
    bad = 0;
    for (int i = 0; i < LANES; i++) if (memVal[8'd160 + AW'(i)] !== expW[i]) bad++;
    chk("R9 result unchanged", bad, 0);
  endtask

  initial begin
    fill_mem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    clean_run("A", 16'h0011, 32'h0000_1000, 8'd16, 8'd40, 8'd100);
    clean_run("edge", 16'h0a0b, 32'hdead_0001, 8'd248, 8'd240, 8'd248);
    t_range("input over", 8'd0, 8'd241, 8'd100);
    t_range("output over", 8'd0, 8'd20, 8'd249);
    t_range("state over", 8'd255, 8'd20, 8'd100);
    t_state_tag();
    t_input_tag();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule